// File: doc/BRIEF.md
# Scanline and Dot Timing Sequencer

This block is the timing backbone of a tile-based video renderer. It runs a horizontal dot counter and a vertical line counter. It sorts each line into one of four kinds: picture line, post-picture line, blanking line or priming line. It also tells a memory fetch unit what kind of access to start on each dot. Lines are numbered so that picture lines start at zero. The single priming line is the last line of the frame, just before line 0 comes round again.

Each memory access takes two dots. A fetch strobe is a one-dot pulse on the odd dot that opens an access slot. Background tiles take groups of eight dots and four accesses. Within a group the accesses come in a fixed order: tile name, attribute, pattern low plane, pattern high plane. The sprite pattern window keeps the two pattern accesses in each group. The first two slots of each group in that window are throw-away name fetches, which a cartridge-side mapper may watch. The priming line runs exactly the fetch schedule of a picture line. The post-picture line and the blanking lines make no fetches.

A render-enable input gates all strobes. The counters never stop, whatever its value.

Top module: `vid_timing_seq`

## Requirements
- R1: A synchronous active-high reset puts the dot counter at 0 and the line counter at 0. That is the first dot of the first picture line.
- R2: The dot counter steps by one each clock from 0 to 340 and then wraps to 0. The line counter advances by one on exactly the clock where the dot wraps.
- R3: After line 261 the line counter wraps to 0, so a frame has 262 lines.
- R4: `line_kind` reads 0 on picture lines 0..239, 1 on post-picture line 240, 2 on blanking lines 241..260 and 3 on priming line 261.
- R5: `vblank` is high on every dot of lines 241..260 and low on all other lines.
- R6: On a fetching line with render enable high, each odd dot d in 1..255 or 321..335 starts one access. Let k = ((d-1)/2) mod 4. Then k=0 raises `fetch_nt`, k=1 `fetch_attr`, k=2 `fetch_pat_lo` and k=3 `fetch_pat_hi`.
- R7: On a fetching line with render enable high, odd dots 257..319 follow the same k rule, except that k=0 and k=1 raise `fetch_nt_dummy`. The dummy fetches therefore fall on 257, 259, 265, 267, ..., 313, 315.
- R8: On a fetching line with render enable high, dots 337 and 339 each raise `fetch_nt`.
- R9: No strobe is ever high on dot 0 or on an even dot. On a fetching line with render enable high, exactly one strobe is high on every odd dot from 1 to 339, so the fetch bus never idles.
- R10: The priming line 261 is a fetching line, with the same strobe pattern as a picture line.
- R11: Lines 240..260 are not fetching lines and raise no strobe.
- R12: While `render_en` is low all five strobes are low, and the counters advance as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one dot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| render_en | input | 1 | Enables fetch strobes |
| dot_cnt | output | 9 | Current dot within the line, 0..340 |
| line_cnt | output | 9 | Current line within the frame, 0..261 |
| line_kind | output | 2 | 0 picture, 1 post-picture, 2 blanking, 3 priming |
| vblank | output | 1 | High throughout the blanking lines |
| fetch_nt | output | 1 | Start of a tile name access |
| fetch_attr | output | 1 | Start of an attribute access |
| fetch_pat_lo | output | 1 | Start of a pattern low-plane access |
| fetch_pat_hi | output | 1 | Start of a pattern high-plane access |
| fetch_nt_dummy | output | 1 | Start of a throw-away name access in the sprite window |

## Verification
A dot counter that skips or sticks shows up on `dot_cnt` the very next cycle. It also shifts the slot phase, so strobes land on the wrong kind or on even dots within one access slot. A line counter that is off shows at the next line boundary. It moves the `vblank` edges and the `line_kind` changes, and it moves the priming line's fetches onto a blanking line, or takes them away. The bench compares every output on every dot of a whole frame against an independent model. Any such error is therefore reported on the first dot where it becomes visible.

// File: rtl/vts_pkg.sv
`timescale 1ns/1ps
package vts_pkg;

   typedef enum logic [1:0] {
      LK_PICTURE = 2'd0,
      LK_POST    = 2'd1,
      LK_BLANK   = 2'd2,
      LK_PRIME   = 2'd3
   } line_kind_e;

   // Access kinds inside one 8-dot group, by slot index.
   typedef enum logic [1:0] {
      SLOT_NAME = 2'd0,
      SLOT_ATTR = 2'd1,
      SLOT_PLO  = 2'd2,
      SLOT_PHI  = 2'd3
   } slot_e;

   typedef struct packed {
      logic nt;
      logic attr;
      logic plo;
      logic phi;
      logic dnt;
   } fetch_stb_t;

endpackage

// File: rtl/vts_dot_counter.sv
`timescale 1ns/1ps
module vts_dot_counter #(
   parameter int DOTS  = 341,
   parameter int DOT_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   output logic [DOT_W-1:0] dot,
   output logic             line_end
);
   localparam logic [DOT_W-1:0] LAST_DOT = DOT_W'(DOTS - 1);

   if (DOTS < 2) begin : g_bad_dots
      $error("vts_dot_counter: DOTS must be at least 2");
   end
   if ((1 << DOT_W) < DOTS) begin : g_bad_dot_w
      $error("vts_dot_counter: DOT_W too narrow for DOTS");
   end

   logic [DOT_W-1:0] dot_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dot_q <= '0;
      end else if (dot_q == LAST_DOT) begin
         dot_q <= '0;
      end else begin
         dot_q <= dot_q + 1'b1;
      end
   end

   assign dot      = dot_q;
   assign line_end = (dot_q == LAST_DOT);

   // R2
   dot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (dot_q == LAST_DOT) |=> (dot_q == '0));

   // R2
   dot_step_chk: assert property (@(posedge clk) disable iff (rst)
      (dot_q != LAST_DOT) |=> (dot_q == $past(dot_q) + 1'b1));

   // R2
   dot_range_chk: assert property (@(posedge clk) disable iff (rst)
      (dot_q <= LAST_DOT));

endmodule

// File: rtl/vts_line_counter.sv
`timescale 1ns/1ps
module vts_line_counter #(
   parameter int LINES  = 262,
   parameter int LINE_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              advance,
   output logic [LINE_W-1:0] line
);
   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

   if ((1 << LINE_W) < LINES) begin : g_bad_line_w
      $error("vts_line_counter: LINE_W too narrow for LINES");
   end

   logic [LINE_W-1:0] line_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         line_q <= '0;
      end else if (advance) begin
         if (line_q == LAST_LINE) begin
            line_q <= '0;
         end else begin
            line_q <= line_q + 1'b1;
         end
      end
   end

   assign line = line_q;

   // R3
   line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (advance && line_q == LAST_LINE) |=> (line_q == '0));

   // R2
   line_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !advance |=> $stable(line_q));

endmodule

// File: rtl/vts_line_classifier.sv
`timescale 1ns/1ps
module vts_line_classifier
   import vts_pkg::*;
#(
   parameter int PIC_LINES   = 240,
   parameter int POST_LINES  = 1,
   parameter int BLANK_LINES = 20,
   parameter int LINE_W      = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LINE_W-1:0] line,
   output line_kind_e        kind,
   output logic              blank,
   output logic              fetch_line
);
   localparam int               TOTAL      = PIC_LINES + POST_LINES + BLANK_LINES + 1;
   localparam logic [LINE_W-1:0] POST_FIRST  = LINE_W'(PIC_LINES);
   localparam logic [LINE_W-1:0] BLANK_FIRST = LINE_W'(PIC_LINES + POST_LINES);
   localparam logic [LINE_W-1:0] PRIME_LINE  = LINE_W'(TOTAL - 1);

   if (PIC_LINES < 1 || BLANK_LINES < 1 || POST_LINES < 0) begin : g_bad_lines
      $error("vts_line_classifier: line counts out of range");
   end

   always_comb begin
      if (line < POST_FIRST) begin
         kind = LK_PICTURE;
      end else if (line < BLANK_FIRST) begin
         kind = LK_POST;
      end else if (line < PRIME_LINE) begin
         kind = LK_BLANK;
      end else begin
         kind = LK_PRIME;
      end
   end

   assign blank      = (line >= BLANK_FIRST) && (line < PRIME_LINE);
   assign fetch_line = (line < POST_FIRST) || (line == PRIME_LINE);

   // R5
   blank_kind_chk: assert property (@(posedge clk) disable iff (rst)
      blank |-> (kind == LK_BLANK));

   // R10
   prime_fetch_chk: assert property (@(posedge clk) disable iff (rst)
      (kind == LK_PRIME) |-> fetch_line);

   // R11
   idle_kind_chk: assert property (@(posedge clk) disable iff (rst)
      (kind == LK_POST || kind == LK_BLANK) |-> !fetch_line);

endmodule

// File: rtl/vts_fetch_decoder.sv
`timescale 1ns/1ps
module vts_fetch_decoder
   import vts_pkg::*;
#(
   parameter int DOTS        = 341,
   parameter int BG_DOTS     = 256,
   parameter int SPR_GROUPS  = 8,
   parameter int PRE_GROUPS  = 2,
   parameter bit TAIL_FETCH  = 1'b1,
   parameter int DOT_W       = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DOT_W-1:0] dot,
   input  logic             fetch_line,
   input  logic             enable,
   output fetch_stb_t       stb
);
   localparam int GROUP      = 8;
   localparam int SPR_FIRST  = BG_DOTS + 1;
   localparam int SPR_LAST   = BG_DOTS + SPR_GROUPS * GROUP;
   localparam int PRE_FIRST  = SPR_LAST + 1;
   localparam int PRE_LAST   = SPR_LAST + PRE_GROUPS * GROUP;
   localparam int TAIL_FIRST = PRE_LAST + 1;

   localparam logic [DOT_W-1:0] BG_HI   = DOT_W'(BG_DOTS);
   localparam logic [DOT_W-1:0] SPR_LO  = DOT_W'(SPR_FIRST);
   localparam logic [DOT_W-1:0] SPR_HI  = DOT_W'(SPR_LAST);
   localparam logic [DOT_W-1:0] PRE_LO  = DOT_W'(PRE_FIRST);
   localparam logic [DOT_W-1:0] PRE_HI  = DOT_W'(PRE_LAST);
   localparam logic [DOT_W-1:0] TAIL_LO = DOT_W'(TAIL_FIRST);

   if (BG_DOTS % GROUP != 0 || BG_DOTS < GROUP) begin : g_bad_bg
      $error("vts_fetch_decoder: BG_DOTS must be a nonzero multiple of 8");
   end
   if (DOTS != TAIL_FIRST + 4) begin : g_bad_span
      $error("vts_fetch_decoder: DOTS must equal the fetch windows plus a 4-dot tail");
   end

   logic             odd_dot;
   logic [DOT_W-1:0] offset;
   slot_e            slot;
   logic             in_bg, in_spr, in_pre, in_tail;
   logic             active;

   assign odd_dot = dot[0];
   assign offset  = dot - 1'b1;
   assign slot    = slot_e'(offset[2:1]);
   assign active  = enable && fetch_line && odd_dot;

   assign in_bg  = (dot != '0) && (dot <= BG_HI);
   assign in_spr = (dot >= SPR_LO) && (dot <= SPR_HI);
   assign in_pre = (dot >= PRE_LO) && (dot <= PRE_HI);

   if (TAIL_FETCH) begin : g_tail
      assign in_tail = (dot >= TAIL_LO);
   end else begin : g_no_tail
      assign in_tail = 1'b0;
   end

   logic tile_win;
   assign tile_win = in_bg || in_pre;

   always_comb begin
      stb = '0;
      if (active) begin
         if (tile_win) begin
            unique case (slot)
               SLOT_NAME: stb.nt   = 1'b1;
               SLOT_ATTR: stb.attr = 1'b1;
               SLOT_PLO:  stb.plo  = 1'b1;
               SLOT_PHI:  stb.phi  = 1'b1;
            endcase
         end else if (in_spr) begin
            unique case (slot)
               SLOT_NAME, SLOT_ATTR: stb.dnt = 1'b1;
               SLOT_PLO:             stb.plo = 1'b1;
               SLOT_PHI:             stb.phi = 1'b1;
            endcase
         end else if (in_tail) begin
            stb.nt = 1'b1;
         end
      end
   end

   // R9
   one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(stb));

   // R9
   even_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !dot[0] |-> (stb == '0));

   // R12
   off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !enable |-> (stb == '0));

   // R11
   line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !fetch_line |-> (stb == '0));

   // R7
   dummy_window_chk: assert property (@(posedge clk) disable iff (rst)
      stb.dnt |-> (dot >= SPR_LO && dot <= SPR_HI));

endmodule

// File: rtl/vid_timing_seq.sv
`timescale 1ns/1ps
module vid_timing_seq
   import vts_pkg::*;
#(
   parameter int DOTS_PER_LINE = 341,
   parameter int PIC_LINES     = 240,
   parameter int POST_LINES    = 1,
   parameter int BLANK_LINES   = 20,
   parameter int BG_DOTS       = 256,
   parameter int SPR_GROUPS    = 8,
   parameter int PRE_GROUPS    = 2,
   parameter bit TAIL_FETCH    = 1'b1,
   localparam int TOTAL_LINES  = PIC_LINES + POST_LINES + BLANK_LINES + 1,
   localparam int DOT_W        = $clog2(DOTS_PER_LINE),
   localparam int LINE_W       = $clog2(TOTAL_LINES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              render_en,
   output logic [DOT_W-1:0]  dot_cnt,
   output logic [LINE_W-1:0] line_cnt,
   output logic [1:0]        line_kind,
   output logic              vblank,
   output logic              fetch_nt,
   output logic              fetch_attr,
   output logic              fetch_pat_lo,
   output logic              fetch_pat_hi,
   output logic              fetch_nt_dummy
);
   localparam logic [DOT_W-1:0]  LAST_DOT    = DOT_W'(DOTS_PER_LINE - 1);
   localparam logic [LINE_W-1:0] BLANK_FIRST = LINE_W'(PIC_LINES + POST_LINES);

   logic       line_end;
   logic       fetch_line;
   line_kind_e kind;
   fetch_stb_t stb;

   vts_dot_counter #(
      .DOTS  (DOTS_PER_LINE),
      .DOT_W (DOT_W)
   ) u_dots (
      .clk      (clk),
      .rst      (rst),
      .dot      (dot_cnt),
      .line_end (line_end)
   );

   vts_line_counter #(
      .LINES  (TOTAL_LINES),
      .LINE_W (LINE_W)
   ) u_lines (
      .clk     (clk),
      .rst     (rst),
      .advance (line_end),
      .line    (line_cnt)
   );

   vts_line_classifier #(
      .PIC_LINES   (PIC_LINES),
      .POST_LINES  (POST_LINES),
      .BLANK_LINES (BLANK_LINES),
      .LINE_W      (LINE_W)
   ) u_class (
      .clk        (clk),
      .rst        (rst),
      .line       (line_cnt),
      .kind       (kind),
      .blank      (vblank),
      .fetch_line (fetch_line)
   );

   vts_fetch_decoder #(
      .DOTS       (DOTS_PER_LINE),
      .BG_DOTS    (BG_DOTS),
      .SPR_GROUPS (SPR_GROUPS),
      .PRE_GROUPS (PRE_GROUPS),
      .TAIL_FETCH (TAIL_FETCH),
      .DOT_W      (DOT_W)
   ) u_fetch (
      .clk        (clk),
      .rst        (rst),
      .dot        (dot_cnt),
      .fetch_line (fetch_line),
      .enable     (render_en),
      .stb        (stb)
   );

   assign line_kind      = kind;
   assign fetch_nt       = stb.nt;
   assign fetch_attr     = stb.attr;
   assign fetch_pat_lo   = stb.plo;
   assign fetch_pat_hi   = stb.phi;
   assign fetch_nt_dummy = stb.dnt;

   // R2
   line_step_chk: assert property (@(posedge clk) disable iff (rst)
      (dot_cnt == LAST_DOT) |=> (line_cnt != $past(line_cnt)));

   // R5
   vblank_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(vblank) |-> (line_cnt == BLANK_FIRST && dot_cnt == '0));

   // R12
   run_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!render_en && dot_cnt != LAST_DOT) |=> (dot_cnt != $past(dot_cnt)));

endmodule

// File: tb/vid_timing_seq_bench.sv
`timescale 1ns/1ps
module vid_timing_seq_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       render_en = 1'b0;
   logic [8:0] dot_cnt, line_cnt;
   logic [1:0] line_kind;
   logic       vblank;
   logic       f_nt, f_at, f_lo, f_hi, f_dn;

   int checks = 0;
   int fails  = 0;
   int exp_dot  = 0;
   int exp_line = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vid_timing_seq u_vid_timing_seq (
      .clk            (clk),
      .rst            (rst),
      .render_en      (render_en),
      .dot_cnt        (dot_cnt),
      .line_cnt       (line_cnt),
      .line_kind      (line_kind),
      .vblank         (vblank),
      .fetch_nt       (f_nt),
      .fetch_attr     (f_at),
      .fetch_pat_lo   (f_lo),
      .fetch_pat_hi   (f_hi),
      .fetch_nt_dummy (f_dn)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s dot=%0d line=%0d actual=%0d expected=%0d",
                  req, exp_dot, exp_line, act, exp);
      end
   endtask

   // Expected strobe vector {nt, attr, pat_lo, pat_hi, dummy}
   function automatic logic [4:0] exp_stb(int d, int l, bit en);
      int k;
      if (!en) return 5'b0;
      if (!(l <= 239 || l == 261)) return 5'b0;
      if (d % 2 == 0) return 5'b0;
      k = ((d - 1) / 2) % 4;
      if (d <= 255 || (d >= 321 && d <= 335)) begin
         case (k)
            0: return 5'b10000;
            1: return 5'b01000;
            2: return 5'b00100;
            default: return 5'b00010;
         endcase
      end
      if (d >= 257 && d <= 319) begin
         if (k < 2) return 5'b00001;
         if (k == 2) return 5'b00100;
         return 5'b00010;
      end
      if (d == 337 || d == 339) return 5'b10000;
      return 5'b0;
   endfunction

   function automatic string stb_req(int d, int l, bit en);
      if (!en) return "R12";
      if (l >= 240 && l <= 260) return "R11";
      if (d % 2 == 0) return "R9";
      if (l == 261) return "R10";
      if (d >= 257 && d <= 319) return "R7";
      if (d >= 337) return "R8";
      return "R6";
   endfunction

   task automatic check_all();
      logic [4:0] got, exp;
      int kind_exp;
      got = {f_nt, f_at, f_lo, f_hi, f_dn};
      exp = exp_stb(exp_dot, exp_line, render_en);
      chk(dot_cnt == 9'(exp_dot), "R2", int'(dot_cnt), exp_dot);
      chk(line_cnt == 9'(exp_line), "R3", int'(line_cnt), exp_line);
      kind_exp = (exp_line <= 239) ? 0 : (exp_line == 240) ? 1 : (exp_line <= 260) ? 2 : 3;
      chk(int'(line_kind) == kind_exp, "R4", int'(line_kind), kind_exp);
      chk(vblank == (exp_line >= 241 && exp_line <= 260), "R5", int'(vblank),
          int'(exp_line >= 241 && exp_line <= 260));
      chk(got == exp, stb_req(exp_dot, exp_line, render_en), int'(got), int'(exp));
      if (render_en && (exp_line <= 239 || exp_line == 261) && exp_dot % 2 == 1)
         chk($countones(got) == 1, "R9", $countones(got), 1);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      if (exp_dot == 340) begin
         exp_dot  = 0;
         exp_line = (exp_line == 261) ? 0 : exp_line + 1;
      end else begin
         exp_dot++;
      end
      check_all();
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      exp_dot  = 0;
      exp_line = 0;
      // R1: reset state
      chk(dot_cnt == 9'd0, "R1", int'(dot_cnt), 0);
      chk(line_cnt == 9'd0, "R1", int'(line_cnt), 0);
      rst = 1'b0;
      check_all();
   endtask

   task automatic t_full_frame();
      bool_wrap_check: begin
      end
      render_en = 1'b1;
      for (int i = 0; i < 341 * 262; i++) begin
         bit at_end;
         at_end = (exp_dot == 340 && exp_line == 261);
         step();
         // R3: frame wrap lands on line 0 dot 0
         if (at_end)
            chk(dot_cnt == 9'd0 && line_cnt == 9'd0, "R3", int'(line_cnt), 0);
      end
   endtask

   task automatic t_disabled();
      int seen;
      seen = 0;
      render_en = 1'b0;
      for (int i = 0; i < 2 * 341; i++) begin
         step();
         if (f_nt | f_at | f_lo | f_hi | f_dn) seen++;
      end
      // R12: no strobe over two picture lines, counters kept running
      chk(seen == 0, "R12", seen, 0);
      chk(line_cnt == 9'd2, "R12", int'(line_cnt), 2);
      render_en = 1'b1;
      for (int i = 0; i < 341; i++) step();
   endtask

   task automatic t_mid_reset();
      for (int i = 0; i < 100; i++) step();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      exp_dot  = 0;
      exp_line = 0;
      // R1: reset mid-line returns to the origin
      chk(dot_cnt == 9'd0, "R1", int'(dot_cnt), 0);
      chk(line_cnt == 9'd0, "R1", int'(line_cnt), 0);
      rst = 1'b0;
      check_all();
      for (int i = 0; i < 20; i++) step();
   endtask

   initial begin
      t_reset();
      t_full_frame();
      t_disabled();
      t_mid_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule